// File: doc/BRIEF.md
# Character LCD First-Line Writer

This block drives a 16x2 character LCD controller through its register-select, read/write and enable strobes and an 8-bit data bus. After reset it waits out the panel's power-on delay. It then issues the power-up command sequence and after that accepts one ASCII character at a time from an upstream producer. The producer uses a valid/ready handshake. Each accepted character is written into display data memory at the next cell of the top line. The controller's own address increment advances the cursor. The first character offered after a full line of 16 causes a clear command. The clear blanks the panel and returns the cursor to cell 0, and the new character is then written there.

All bus timing counts in ticks of a slow enable, nominally 1 us, divided down from the system clock. The first three function-set commands are spaced by fixed waits. Every later access is preceded by a status read that polls the controller's busy flag on data bit 7 and repeats until that bit reads 0. During reads the block stops driving the data bus.

Top module: `lcd_line_writer`

## Requirements
- R1: While reset is low and until the power-up sequence ends, `char_ready_o` is 0. Until the first access, `lcd_e_o` and `lcd_data_oe_o` are 0.
- R2: The first enable pulse rises no earlier than PWR_TICKS ticks after reset is released.
- R3: The power-up writes, all with RS=0, are 0x38, 0x38, 0x38, 0x0C, 0x01, 0x06 in that order. At least WAIT1_TICKS ticks pass between the end of the first and the start of the second, and at least WAIT2_TICKS ticks between the second and the third.
- R4: Every write after the third one is preceded by status reads (RS=0, RW=1). The reads repeat while data bit 7 reads 1, and no write starts while the controller is busy.
- R5: An enable pulse stays high for at least one tick. RS and RW are stable for at least one tick before it rises and stay stable while it is high.
- R6: `lcd_data_oe_o` is 0 whenever `lcd_rw_o` is 1.
- R7: A character is taken on a clock edge where both `char_valid_i` and `char_ready_o` are 1. Ready is 0 in the next cycle and stays 0 until that character's write has finished. Valid has no effect while ready is 0.
- R8: Characters are written as data (RS=1, RW=0) with the accepted byte, in acceptance order, into cells 0 to 15 of the line.
- R9: When 16 characters are on the line, the next accepted character is preceded by a clear command 0x01 with RS=0, and that character lands in cell 0.
- R10: While `char_ready_o` is 1, no enable pulse is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_valid_i | input | 1 | Upstream character is valid |
| char_i | input | 8 | ASCII character code |
| char_ready_o | output | 1 | Block can take a character |
| lcd_rs_o | output | 1 | Register select: 0 = instruction/status, 1 = data |
| lcd_rw_o | output | 1 | 1 = read, 0 = write |
| lcd_e_o | output | 1 | Enable strobe |
| lcd_data_o | output | 8 | Data bus value driven on writes |
| lcd_data_i | input | 8 | Data bus value read back; bit 7 is the busy flag |
| lcd_data_oe_o | output | 1 | Data bus driver enable |

## Verification
The hardest case to reach is the line wrap with a busy controller. The clear must be issued, polled until it is done and followed by the new character, with ready held low through all of it. The bench drives 40 random printable characters, with random gaps and some back-to-back offers, so the 16- and 32-character boundaries are crossed. Its display model reports busy for a random time after each write, which forces repeated status reads before both the clear and the character that follows. A character offered during power-up checks that valid is ignored while ready is low.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam logic [7:0] CMD_FUNC    = 8'h38;
  localparam logic [7:0] CMD_DISP_ON = 8'h0C;
  localparam logic [7:0] CMD_CLEAR   = 8'h01;
  localparam logic [7:0] CMD_ENTRY   = 8'h06;
  localparam int unsigned INIT_STEPS = 6;
  localparam int unsigned BUSY_BIT   = 7;

  typedef enum logic [2:0] {
    ST_PWR, ST_WR, ST_WAIT, ST_POLL, ST_IDLE
  } seq_st_e;

  function automatic logic [7:0] init_cmd(input logic [2:0] idx);
    case (idx)
      3'd0, 3'd1, 3'd2: init_cmd = CMD_FUNC;
      3'd3:             init_cmd = CMD_DISP_ON;
      3'd4:             init_cmd = CMD_CLEAR;
      default:          init_cmd = CMD_ENTRY;
    endcase
  endfunction
endpackage

// File: rtl/lcd_tick_gen.sv
module lcd_tick_gen #(
  parameter int unsigned DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lcd_bus_engine.sv
// One bus access: setup (partial + full tick), E high one tick, hold one tick.
module lcd_bus_engine (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       req_i,
  input  logic       req_rs_i,
  input  logic       req_rw_i,
  input  logic [7:0] req_data_i,
  output logic       done_o,
  output logic [7:0] rd_data_o,
  output logic       lcd_rs_o,
  output logic       lcd_rw_o,
  output logic       lcd_e_o,
  output logic [7:0] lcd_data_o,
  input  logic [7:0] lcd_data_i,
  output logic       lcd_data_oe_o
);
  logic       active_q, rs_q, rw_q, e_q, oe_q;
  logic [1:0] ph_q;
  logic [7:0] dat_q, rd_q;

  assign done_o        = active_q && (ph_q == 2'd3) && tick_i;
  assign rd_data_o     = rd_q;
  assign lcd_rs_o      = rs_q;
  assign lcd_rw_o      = rw_q;
  assign lcd_e_o       = e_q;
  assign lcd_data_o    = dat_q;
  assign lcd_data_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ph_q     <= 2'd0;
      rs_q     <= 1'b0;
      rw_q     <= 1'b1;
      e_q      <= 1'b0;
      oe_q     <= 1'b0;
      dat_q    <= '0;
      rd_q     <= '0;
    end else if (!active_q) begin
      if (req_i) begin
        active_q <= 1'b1;
        ph_q     <= 2'd0;
        rs_q     <= req_rs_i;
        rw_q     <= req_rw_i;
        oe_q     <= !req_rw_i;
        dat_q    <= req_data_i;
      end
    end else if (tick_i) begin
      case (ph_q)
        2'd0: ph_q <= 2'd1;
        2'd1: begin ph_q <= 2'd2; e_q <= 1'b1; end
        2'd2: begin
          ph_q <= 2'd3;
          e_q  <= 1'b0;
          if (rw_q) rd_q <= lcd_data_i;
        end
        default: begin
          active_q <= 1'b0;
          ph_q     <= 2'd0;
          rs_q     <= 1'b0;
          rw_q     <= 1'b1;
          oe_q     <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/lcd_seq.sv
module lcd_seq
  import lcd_pkg::*;
#(
  parameter int unsigned PWR_TICKS   = 15000,
  parameter int unsigned WAIT1_TICKS = 4100,
  parameter int unsigned WAIT2_TICKS = 100,
  parameter int unsigned LINE_COLS   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       char_valid_i,
  input  logic [7:0] char_i,
  output logic       char_ready_o,
  output logic       bus_req_o,
  output logic       bus_rs_o,
  output logic       bus_rw_o,
  output logic [7:0] bus_data_o,
  input  logic       bus_done_i,
  input  logic [7:0] bus_rd_i
);
  localparam int unsigned MAXT  = (PWR_TICKS > WAIT1_TICKS) ?
                                  ((PWR_TICKS > WAIT2_TICKS) ? PWR_TICKS : WAIT2_TICKS) :
                                  ((WAIT1_TICKS > WAIT2_TICKS) ? WAIT1_TICKS : WAIT2_TICKS);
  localparam int unsigned CNT_W = $clog2(MAXT + 1);
  localparam int unsigned COL_W = $clog2(LINE_COLS + 1);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q, lim_q;
  logic [2:0]       init_idx_q;
  logic             run_q, op_rs_q;
  logic [7:0]       op_byte_q, ch_q;
  logic [COL_W-1:0] col_q;

  assign char_ready_o = (st_q == ST_IDLE);
  assign bus_req_o    = (st_q == ST_WR) || (st_q == ST_POLL);
  assign bus_rw_o     = (st_q == ST_POLL);
  assign bus_rs_o     = (st_q == ST_WR) && op_rs_q;
  assign bus_data_o   = op_byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_PWR;
      cnt_q      <= '0;
      lim_q      <= CNT_W'(PWR_TICKS);
      init_idx_q <= '0;
      run_q      <= 1'b0;
      op_rs_q    <= 1'b0;
      op_byte_q  <= init_cmd(3'd0);
      ch_q       <= '0;
      col_q      <= '0;
    end else begin
      case (st_q)
        ST_PWR, ST_WAIT: if (tick_i) begin
          if (cnt_q == lim_q - 1'b1) begin
            cnt_q <= '0;
            st_q  <= ST_WR;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WR: if (bus_done_i) begin
          if (!run_q) begin
            if (init_idx_q == 3'(INIT_STEPS - 1)) begin
              run_q <= 1'b1;
              st_q  <= ST_IDLE;
            end else begin
              init_idx_q <= init_idx_q + 1'b1;
              op_byte_q  <= init_cmd(init_idx_q + 1'b1);
              if (init_idx_q == 3'd0) begin
                lim_q <= CNT_W'(WAIT1_TICKS);
                st_q  <= ST_WAIT;
              end else if (init_idx_q == 3'd1) begin
                lim_q <= CNT_W'(WAIT2_TICKS);
                st_q  <= ST_WAIT;
              end else begin
                st_q <= ST_POLL;
              end
            end
          end else if (!op_rs_q) begin
            // clear done: the held character goes to cell 0
            col_q     <= '0;
            op_rs_q   <= 1'b1;
            op_byte_q <= ch_q;
            st_q      <= ST_POLL;
          end else begin
            col_q <= col_q + 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        ST_POLL: if (bus_done_i && !bus_rd_i[BUSY_BIT]) st_q <= ST_WR;
        ST_IDLE: if (char_valid_i) begin
          ch_q <= char_i;
          if (col_q == COL_W'(LINE_COLS)) begin
            op_rs_q   <= 1'b0;
            op_byte_q <= CMD_CLEAR;
          end else begin
            op_rs_q   <= 1'b1;
            op_byte_q <= char_i;
          end
          st_q <= ST_POLL;
        end
        default: st_q <= ST_PWR;
      endcase
    end
  end
endmodule

// File: rtl/lcd_line_writer.sv
module lcd_line_writer #(
  parameter int unsigned CLK_DIV     = 50,
  parameter int unsigned PWR_TICKS   = 15000,
  parameter int unsigned WAIT1_TICKS = 4100,
  parameter int unsigned WAIT2_TICKS = 100,
  parameter int unsigned LINE_COLS   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       char_valid_i,
  input  logic [7:0] char_i,
  output logic       char_ready_o,
  output logic       lcd_rs_o,
  output logic       lcd_rw_o,
  output logic       lcd_e_o,
  output logic [7:0] lcd_data_o,
  input  logic [7:0] lcd_data_i,
  output logic       lcd_data_oe_o
);
  logic       tick, bus_req, bus_rs, bus_rw, bus_done;
  logic [7:0] bus_data, bus_rd;

  lcd_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  lcd_seq #(
    .PWR_TICKS   (PWR_TICKS),
    .WAIT1_TICKS (WAIT1_TICKS),
    .WAIT2_TICKS (WAIT2_TICKS),
    .LINE_COLS   (LINE_COLS)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .char_valid_i (char_valid_i),
    .char_i       (char_i),
    .char_ready_o (char_ready_o),
    .bus_req_o    (bus_req),
    .bus_rs_o     (bus_rs),
    .bus_rw_o     (bus_rw),
    .bus_data_o   (bus_data),
    .bus_done_i   (bus_done),
    .bus_rd_i     (bus_rd)
  );

  lcd_bus_engine u_bus (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick),
    .req_i         (bus_req),
    .req_rs_i      (bus_rs),
    .req_rw_i      (bus_rw),
    .req_data_i    (bus_data),
    .done_o        (bus_done),
    .rd_data_o     (bus_rd),
    .lcd_rs_o      (lcd_rs_o),
    .lcd_rw_o      (lcd_rw_o),
    .lcd_e_o       (lcd_e_o),
    .lcd_data_o    (lcd_data_o),
    .lcd_data_i    (lcd_data_i),
    .lcd_data_oe_o (lcd_data_oe_o)
  );
endmodule

// File: rtl/lcd_line_writer_chk.sv
module lcd_line_writer_chk #(
  parameter int unsigned CLK_DIV = 50
) (
  input logic clk_i,
  input logic rst_ni,
  input logic char_valid_i,
  input logic char_ready_o,
  input logic lcd_rs_o,
  input logic lcd_rw_o,
  input logic lcd_e_o,
  input logic lcd_data_oe_o
);
  localparam int unsigned CW = $clog2(CLK_DIV + 2) + 1;
  localparam logic [CW-1:0] SAT = '1;

  logic          rs_d, rw_d;
  logic [CW-1:0] setup_cnt, hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs_d      <= 1'b0;
      rw_d      <= 1'b1;
      setup_cnt <= '0;
      hi_cnt    <= '0;
    end else begin
      rs_d <= lcd_rs_o;
      rw_d <= lcd_rw_o;
      if (lcd_rs_o != rs_d || lcd_rw_o != rw_d) setup_cnt <= '0;
      else if (setup_cnt != SAT)                setup_cnt <= setup_cnt + 1'b1;
      if (!lcd_e_o)           hi_cnt <= '0;
      else if (hi_cnt != SAT) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R5
  e_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lcd_e_o) |-> setup_cnt >= CW'(CLK_DIV));
  // R5
  e_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lcd_e_o) |-> hi_cnt >= CW'(CLK_DIV));
  // R5
  e_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_e_o && $past(lcd_e_o) |-> $stable(lcd_rs_o) && $stable(lcd_rw_o));
  // R6
  bus_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_rw_o |-> !lcd_data_oe_o);
  // R7
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_i && char_ready_o |=> !char_ready_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_ready_o |-> !lcd_e_o);
  // R8
  data_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_e_o && lcd_rs_o |-> !lcd_rw_o);
endmodule

bind lcd_line_writer lcd_line_writer_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .char_valid_i  (char_valid_i),
  .char_ready_o  (char_ready_o),
  .lcd_rs_o      (lcd_rs_o),
  .lcd_rw_o      (lcd_rw_o),
  .lcd_e_o       (lcd_e_o),
  .lcd_data_oe_o (lcd_data_oe_o)
);

// File: tb/tb_lcd_line_writer.sv
`timescale 1ns/1ps
module tb_lcd_line_writer;
  localparam int DIV = 4, PWR = 40, W1 = 12, W2 = 3, COLS = 16, NCH = 40, LOGN = 256;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [7:0] ch = '0;
  logic       ready, rs, rw, e, oe;
  logic [7:0] dout, din = '0;

  lcd_line_writer #(.CLK_DIV(DIV), .PWR_TICKS(PWR), .WAIT1_TICKS(W1),
                    .WAIT2_TICKS(W2), .LINE_COLS(COLS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .char_valid_i(valid), .char_i(ch),
    .char_ready_o(ready), .lcd_rs_o(rs), .lcd_rw_o(rw), .lcd_e_o(e),
    .lcd_data_o(dout), .lcd_data_i(din), .lcd_data_oe_o(oe));

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // display model and bus log
  int        cyc = 0, rel_cyc = 0;
  logic      e_prev = 1'b0;
  int        busy_cnt = 0, nwr = 0, busy_polls = 0, oe_viol = 0, first_rise = -1;
  logic      log_rs [LOGN];
  logic [7:0] log_d [LOGN];
  int        fall_t [LOGN];
  int        rise_t [LOGN];
  logic [7:0] disp [COLS];
  int        addr = 0;
  logic [7:0] sent [NCH];

  always @(posedge clk) cyc <= cyc + 1;

  initial for (int i = 0; i < COLS; i++) disp[i] = 8'h20;

  always @(negedge clk) if (rst_n) begin
    if (rw && oe) oe_viol++;
    if (busy_cnt > 0) busy_cnt--;
    if (e && !e_prev) begin
      if (first_rise < 0) first_rise = cyc - rel_cyc;
      if (!rw) begin
        if (nwr < LOGN) rise_t[nwr] = cyc;
        if (nwr >= 3) chk(busy_cnt == 0, "R4 write while busy", busy_cnt, 0);
      end else if (busy_cnt > 0) busy_polls++;
    end
    if (!e && e_prev && !rw && nwr < LOGN) begin
      log_rs[nwr] = rs;
      log_d[nwr]  = dout;
      fall_t[nwr] = cyc;
      if (rs) begin
        chk(addr < COLS, "R9 write past line end", addr, COLS - 1);
        if (addr < COLS) disp[addr] = dout;
        addr++;
      end else if (dout == 8'h01) begin
        for (int i = 0; i < COLS; i++) disp[i] = 8'h20;
        addr = 0;
      end
      busy_cnt = (nwr >= 2) ? int'($urandom_range(0, 90)) : 0;
      nwr++;
    end
    din    <= {busy_cnt != 0, 7'h00};
    e_prev = e;
  end

  function automatic logic [7:0] exp_init(input int i);
    case (i)
      0, 1, 2: return 8'h38;
      3:       return 8'h0C;
      4:       return 8'h01;
      default: return 8'h06;
    endcase
  endfunction

  function automatic logic [7:0] exp_cell(input int p);
    int base = ((NCH - 1) / COLS) * COLS;
    if (p < NCH - base) return sent[base + p];
    return 8'h20;
  endfunction

  task automatic send(input logic [7:0] c, input int k);
    int widx;
    while (!ready) @(negedge clk);
    valid = 1'b1;
    ch    = c;
    @(negedge clk);
    valid = 1'b0;
    ch    = $urandom_range(0, 255);
    chk(!ready, "R7 ready drops after accept", ready, 0);
    widx = nwr;
    while (!ready) @(negedge clk);
    // R7 / R10: ready returns only after the data write
    chk(nwr > 0 && log_rs[nwr-1] && log_d[nwr-1] == c, "R7 ready after write",
        int'(log_d[nwr-1]), int'(c));
    if (k > 0 && k % COLS == 0)
      chk(nwr - widx == 2 && !log_rs[widx] && log_d[widx] == 8'h01,
          "R9 clear before wrap char", int'(log_d[widx]), 8'h01);
  endtask

  initial begin
    int idx;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!ready && !e && !oe, "R1 reset outputs", {ready, e, oe}, 0);
    rst_n = 1'b1;
    @(posedge clk);
    rel_cyc = cyc - 1;
    // R7: offer a character during power-up; it must be ignored
    @(negedge clk);
    valid = 1'b1;
    ch    = 8'h51;
    repeat (30) @(negedge clk);
    chk(!ready && !e && !oe, "R1 idle during power wait", {ready, e, oe}, 0);
    valid = 1'b0;
    while (!ready) @(negedge clk);
    chk(first_rise >= PWR * DIV, "R2 power-on wait", first_rise, PWR * DIV);
    chk(nwr == 6, "R3 init write count", nwr, 6);
    for (int i = 0; i < 6; i++)
      chk(!log_rs[i] && log_d[i] == exp_init(i), "R3 init command", int'(log_d[i]),
          int'(exp_init(i)));
    chk(rise_t[1] - fall_t[0] >= W1 * DIV, "R3 first wait", rise_t[1] - fall_t[0], W1 * DIV);
    chk(rise_t[2] - fall_t[1] >= W2 * DIV, "R3 second wait", rise_t[2] - fall_t[1], W2 * DIV);
    // random printable characters, random gaps
    for (int k = 0; k < NCH; k++) begin
      sent[k] = 8'($urandom_range(8'h20, 8'h7E));
      if (k == 15 || k == 16 || k == 31) sent[k] = 8'h7E;
      if ($urandom_range(0, 2) != 0) repeat ($urandom_range(1, 20)) @(negedge clk);
      send(sent[k], k);
    end
    repeat (40) @(negedge clk);
    // R8 / R9 full write order
    idx = 6;
    for (int k = 0; k < NCH; k++) begin
      if (k > 0 && k % COLS == 0) begin
        chk(!log_rs[idx] && log_d[idx] == 8'h01, "R9 clear in sequence", int'(log_d[idx]), 8'h01);
        idx++;
      end
      chk(log_rs[idx] && log_d[idx] == sent[k], "R8 data write order", int'(log_d[idx]),
          int'(sent[k]));
      idx++;
    end
    chk(nwr == idx, "R8 no extra writes", nwr, idx);
    for (int p = 0; p < COLS; p++)
      chk(disp[p] == exp_cell(p), "R8 display cell", int'(disp[p]), int'(exp_cell(p)));
    chk(busy_polls > 0, "R4 busy polls repeated", busy_polls, 1);
    chk(oe_viol == 0, "R6 bus released on reads", oe_viol, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule